// File: doc/BRIEF.md
# Two-Road Demand-Driven Green Arbiter

This block decides which of two crossing roads, north-south or east-west, gets a green light. Each road has a car-presence sensor. The green stays with the current road until a car waits on the other road while the current road is empty. Only then does the green move across. There are no timed phases and no amber interval, so the light changes purely on demand.

Internally the block is a two-state Moore machine built from three parts: a phase register, a next-phase decision, and a green decoder. The green outputs depend only on the stored phase, so sensor changes between clock edges never reach the lamps directly. An asynchronous active-high reset returns the green to north-south.

Top module: `xroad_green_ctrl`

## Requirements
- R1: While `rst_i` is high, and after it falls until a transition is taken, the phase is north-south and `green_o` is 2'b01.
- R2: After reset, `green_o` has exactly one bit set in every cycle: 2'b01 means north-south green (bit 0) and 2'b10 means east-west green (bit 1). The values 2'b00 and 2'b11 never appear.
- R3: In the north-south phase, `sense_i` of 2'b10 at a rising clock edge moves the block to the east-west phase. Bit 1 means a car on east-west and bit 0 means a car on north-south. `green_o` reads 2'b10 right after that edge.
- R4: In the north-south phase, `sense_i` of 2'b00, 2'b01 or 2'b11 at a rising edge leaves `green_o` at 2'b01.
- R5: In the east-west phase, `sense_i` of 2'b01 at a rising edge moves the block to north-south, and `green_o` reads 2'b01 right after that edge.
- R6: In the east-west phase, `sense_i` of 2'b00, 2'b10 or 2'b11 at a rising edge leaves `green_o` at 2'b10.
- R7: Between clock edges, a change on `sense_i` has no effect on `green_o`.
- R8: Raising `rst_i` forces `green_o` to 2'b01 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the phase updates on its rising edge |
| rst_i | input | 1 | Asynchronous reset, active high |
| sense_i | input | 2 | Car sensors: bit 0 north-south, bit 1 east-west |
| green_o | output | 2 | One-hot green: bit 0 north-south, bit 1 east-west |

## Verification
A wrong stored phase shows up as the wrong lamp on `green_o` in the cycle right after the edge that stored it. The phase register is the only state, so the error cannot stay hidden for more than one cycle. A faulty decision for one sensor pattern is seen only when that pattern is applied in the matching phase. For that reason the bench applies all four sensor codes in both phases. A decoder fault that produces 2'b00 or 2'b11 is caught in any cycle by the one-hot check.

// File: rtl/xroad_pkg.sv
package xroad_pkg;
  localparam int unsigned ROADS = 2;

  typedef enum logic {
    PH_NS = 1'b0,
    PH_EW = 1'b1
  } phase_e;

  // The green moves only when the idle road has demand and the served road is empty.
  function automatic phase_e next_phase(input phase_e cur, input logic [ROADS-1:0] sense);
    phase_e nxt;
    nxt = cur;
    case (cur)
      PH_NS: if (sense[1] && !sense[0]) nxt = PH_EW;
      PH_EW: if (sense[0] && !sense[1]) nxt = PH_NS;
      default: nxt = PH_NS;
    endcase
    return nxt;
  endfunction

  // Each phase lights the lamp whose bit index equals the phase value.
  function automatic logic [ROADS-1:0] green_of(input phase_e cur);
    logic [ROADS-1:0] g;
    g = '0;
    g[cur] = 1'b1;
    return g;
  endfunction
endpackage

// File: rtl/xroad_phase_reg.sv
module xroad_phase_reg
  import xroad_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  phase_e phase_d,
  output phase_e phase_q
);
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) phase_q <= PH_NS;
    else       phase_q <= phase_d;
  end
endmodule

// File: rtl/xroad_next_phase.sv
module xroad_next_phase
  import xroad_pkg::*;
(
  input  phase_e            phase_q,
  input  logic [ROADS-1:0]  sense_i,
  output phase_e            phase_d
);
  always_comb phase_d = next_phase(phase_q, sense_i);
endmodule

// File: rtl/xroad_green_dec.sv
module xroad_green_dec
  import xroad_pkg::*;
(
  input  phase_e           phase_q,
  output logic [ROADS-1:0] green_o
);
  always_comb green_o = green_of(phase_q);
endmodule

// File: rtl/xroad_green_ctrl.sv
module xroad_green_ctrl
  import xroad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [ROADS-1:0] sense_i,
  output logic [ROADS-1:0] green_o
);
  phase_e phase_q;
  phase_e phase_d;
  logic   ew_demand_only;
  logic   ns_demand_only;

  assign ew_demand_only = (sense_i == 2'b10);
  assign ns_demand_only = (sense_i == 2'b01);

  xroad_phase_reg u_reg (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .phase_d (phase_d),
    .phase_q (phase_q)
  );

  xroad_next_phase u_next (
    .phase_q (phase_q),
    .sense_i (sense_i),
    .phase_d (phase_d)
  );

  xroad_green_dec u_dec (
    .phase_q (phase_q),
    .green_o (green_o)
  );

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(green_o) == 1);

  a_r3_ns_to_ew: assert property (@(posedge clk_i) disable iff (rst_i)
    (green_o == 2'b01 && ew_demand_only) |=> (green_o == 2'b10));

  a_r4_ns_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (green_o == 2'b01 && !ew_demand_only) |=> (green_o == 2'b01));

  a_r5_ew_to_ns: assert property (@(posedge clk_i) disable iff (rst_i)
    (green_o == 2'b10 && ns_demand_only) |=> (green_o == 2'b01));

  a_r6_ew_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (green_o == 2'b10 && !ns_demand_only) |=> (green_o == 2'b10));

  a_r7_lamp_follows_phase: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == $past(phase_q)) |-> $stable(green_o));
endmodule

// File: tb/xroad_green_ctrl_bench.sv
module xroad_green_ctrl_bench;
  localparam time CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [1:0] sense_i = 2'b00;
  logic [1:0] green_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  xroad_green_ctrl u_xroad_green_ctrl (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sense_i (sense_i),
    .green_o (green_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (green_o !== exp) begin
      errors++;
      $display("FAIL %s: green_o=%b expected=%b at %0t", req, green_o, exp, $time);
    end
    if (!rst_i) begin
      checks++;
      if (green_o !== 2'b01 && green_o !== 2'b10) begin
        errors++;
        $display("FAIL R2: green_o=%b expected one-hot at %0t", green_o, $time);
      end
    end
  endtask

  // Present a sensor code before an edge and check the lamp just after it.
  task automatic step(input logic [1:0] s, input string req, input logic [1:0] exp);
    @(negedge clk_i);
    sense_i = s;
    @(posedge clk_i);
    #1;
    check(req, exp);
  endtask

  task automatic t_reset();
    rst_i = 1'b1;
    #1 check("R1", 2'b01);
    @(negedge clk_i);
    rst_i = 1'b0;
    step(2'b00, "R1", 2'b01);
  endtask

  task automatic t_ns_hold();
    step(2'b00, "R4", 2'b01);
    step(2'b01, "R4", 2'b01);
    step(2'b11, "R4", 2'b01);
  endtask

  task automatic t_ns_to_ew();
    step(2'b10, "R3", 2'b10);
  endtask

  task automatic t_ew_hold();
    step(2'b00, "R6", 2'b10);
    step(2'b10, "R6", 2'b10);
    step(2'b11, "R6", 2'b10);
  endtask

  task automatic t_ew_to_ns();
    step(2'b01, "R5", 2'b01);
  endtask

  task automatic t_between_edges();
    @(negedge clk_i);
    sense_i = 2'b10;
    #1 check("R7", 2'b01);
    sense_i = 2'b01;
    #1 check("R7", 2'b01);
    sense_i = 2'b10;
    #1 check("R7", 2'b01);
    @(posedge clk_i);
    #1 check("R3", 2'b10);
    @(negedge clk_i);
    sense_i = 2'b01;
    #1 check("R7", 2'b10);
    sense_i = 2'b11;
    @(posedge clk_i);
    #1 check("R6", 2'b10);
  endtask

  task automatic t_async_reset();
    @(negedge clk_i);
    #1 rst_i = 1'b1;
    #1 check("R8", 2'b01);
    sense_i = 2'b10;
    @(posedge clk_i);
    #1 check("R1", 2'b01);
    @(negedge clk_i);
    rst_i = 1'b0;
    sense_i = 2'b00;
    @(posedge clk_i);
    #1 check("R1", 2'b01);
  endtask

  initial begin
    t_reset();
    t_ns_hold();
    t_ns_to_ew();
    t_ew_hold();
    t_ew_to_ns();
    t_ns_hold();
    t_between_edges();
    t_async_reset();
    t_ns_to_ew();
    t_ew_to_ns();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule